// File: doc/BRIEF.md
# Multi-mode logic element

A single programmable logic cell for a configurable fabric. Static configuration inputs pick one of three run-time modes. In the plain lookup mode, one 4-input table drives the output. In the adder mode, the table is split into two 3-input tables. The lower table makes a sum from two data inputs and a carry-in, and the upper table makes the carry-out. The counter mode uses the same split tables, but the cell's own register replaces the lowest data input, and synchronous clear and load act on the register.

The table result passes through a cascade stage in every mode. That stage ANDs or ORs the result with a cascade input from the neighbouring cell. The cascade result appears both as the combinational output and as the cascade output.

One register follows the cascade stage. It takes one of two shared clocks and one of two shared clock enables. Either of two shared block clears can be enabled to force the register asynchronously to a configured value (clear or preset). The chip reset overrides everything.

Top module: `multimode_le`

## Requirements
- R1: `cfg_mode_i` encodes the mode as 0 = lookup, 1 = adder, 2 = counter. Code 3 behaves exactly like code 0.
- R2: In lookup mode the table result is `cfg_mask_i[data_i]`, with `data_i[0]` as the least significant index bit.
- R3: In lookup mode `cout_o` is 0 whatever the mask.
- R4: In adder mode the index is {`cin_i`, `data_i[1]`, `data_i[0]`}. The table result is `cfg_mask_i[index]` and `cout_o` is `cfg_mask_i[8+index]`.
- R5: In every mode `comb_o` and `casc_o` both equal the table result AND `casc_i` when `cfg_casc_or_i` is 0, and the table result OR `casc_i` when it is 1.
- R6: In counter mode the index is {`cin_i`, `data_i[1]`, `reg_o`}. On an enabled clock edge with neither clear nor load, the register takes `comb_o`.
- R7: In counter mode, on an enabled edge `sclr_i` forces the register to 0. This beats `sload_i`, which loads `data_i[2]`, and that in turn beats counting.
- R8: In lookup and adder modes an enabled edge captures `comb_o`. `sclr_i` and `sload_i` have no effect.
- R9: The clock enable is `ena0_i` when `cfg_ena_sel_i` is 0 and `ena1_i` when it is 1. While the selected enable is low the register holds, even under synchronous clear or load.
- R10: The register is clocked by `clk0_i` when `cfg_clk_sel_i` is 0 and by `clk1_i` when it is 1. Edges of the clock that is not selected have no effect.
- R11: Bit 0 of `cfg_aclr_sel_i` enables `blk_clr0_i` and bit 1 enables `blk_clr1_i`. While an enabled clear is high, the register takes `cfg_apre_i` at once, over any synchronous action. A clear that is not enabled is ignored.
- R12: While `rst_ni` is low the register is 0. This overrides every other control, and `reg_o` is 0 out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0_i | input | 1 | Shared clock 0 |
| clk1_i | input | 1 | Shared clock 1 |
| rst_ni | input | 1 | Chip reset, active low, asynchronous |
| blk_clr0_i | input | 1 | Shared block clear 0, active high, asynchronous |
| blk_clr1_i | input | 1 | Shared block clear 1, active high, asynchronous |
| ena0_i | input | 1 | Shared clock enable 0 |
| ena1_i | input | 1 | Shared clock enable 1 |
| cfg_mask_i | input | 16 | Lookup table contents |
| cfg_mode_i | input | 2 | Mode select |
| cfg_casc_or_i | input | 1 | Cascade operation: 0 AND, 1 OR |
| cfg_clk_sel_i | input | 1 | Register clock select |
| cfg_ena_sel_i | input | 1 | Clock enable select |
| cfg_aclr_sel_i | input | 2 | Enable mask for the two block clears |
| cfg_apre_i | input | 1 | Value forced by an enabled block clear |
| data_i | input | 4 | Data inputs |
| cin_i | input | 1 | Carry in |
| casc_i | input | 1 | Cascade in |
| sload_i | input | 1 | Synchronous load (counter mode) |
| sclr_i | input | 1 | Synchronous clear (counter mode) |
| comb_o | output | 1 | Combinational output after the cascade stage |
| reg_o | output | 1 | Registered output |
| cout_o | output | 1 | Carry out |
| casc_o | output | 1 | Cascade out |

## Verification
`comb_o`, `casc_o` and `cout_o` settle in the same cycle as their inputs. Only in counter mode do they also depend on `reg_o`, and so change after a clock edge. `reg_o` changes on the first selected clock edge after a synchronous stimulus, and at once on an asynchronous clear or reset. The bench drives inputs 1 ns after the falling edge of `clk0_i`. A behavioural model updates only on edges of the selected clock, and the bench compares all four outputs against it on every falling edge, half a period after any capture. Asynchronous stimuli are held across a rising edge, so the model, which acts on clock edges, agrees with the design at every compare.

// File: rtl/mle_pkg.sv
package mle_pkg;
  typedef enum logic [1:0] {
    MODE_LUT   = 2'd0,
    MODE_ADD   = 2'd1,
    MODE_CNT   = 2'd2,
    MODE_LUT_B = 2'd3
  } le_mode_e;

  function automatic logic is_lut_mode(le_mode_e m);
    return (m == MODE_LUT) || (m == MODE_LUT_B);
  endfunction
endpackage

// File: rtl/mle_lut.sv
module mle_lut #(
  parameter int K = 4,
  localparam int W = 1 << K
) (
  input  logic [W-1:0] mask_i,
  input  logic [K-1:0] sel_i,
  output logic         out_o
);
  assign out_o = mask_i[sel_i];
endmodule

// File: rtl/mle_ctrl.sv
// shared clock / enable / async clear selection
module mle_ctrl #(
  parameter int NSH = 2,
  localparam int SW = (NSH > 1) ? $clog2(NSH) : 1
) (
  input  logic [NSH-1:0] clk_i,
  input  logic [NSH-1:0] ena_i,
  input  logic [NSH-1:0] clr_i,
  input  logic [SW-1:0]  clk_sel_i,
  input  logic [SW-1:0]  ena_sel_i,
  input  logic [NSH-1:0] clr_en_i,
  output logic           clk_o,
  output logic           ena_o,
  output logic           aclr_o
);
  // config is static; switch only while both clocks are low
  assign clk_o  = clk_i[clk_sel_i];
  assign ena_o  = ena_i[ena_sel_i];
  assign aclr_o = |(clr_i & clr_en_i);
endmodule

// File: rtl/mle_datapath.sv
module mle_datapath
  import mle_pkg::*;
#(
  parameter int K = 4,
  localparam int W  = 1 << K,
  localparam int HW = W / 2
) (
  input  le_mode_e     mode_i,
  input  logic [W-1:0] mask_i,
  input  logic         casc_or_i,
  input  logic [K-1:0] data_i,
  input  logic         cin_i,
  input  logic         casc_i,
  input  logic         q_i,
  output logic         comb_o,
  output logic         cout_o
);
  logic         lut_mode;
  logic         cnt_mode;
  logic [K-2:0] half_idx;
  logic         f_full;
  logic [1:0]   f_half;
  logic         f_sel;

  assign lut_mode = is_lut_mode(mode_i);
  assign cnt_mode = (mode_i == MODE_CNT);
  // counter mode feeds register back in place of lowest data bit
  assign half_idx = {cin_i, data_i[K-3:1], cnt_mode ? q_i : data_i[0]};

  mle_lut #(.K(K)) u_full (
    .mask_i(mask_i),
    .sel_i (data_i),
    .out_o (f_full)
  );

  // h=0: sum table, h=1: carry table
  for (genvar h = 0; h < 2; h++) begin : g_half
    mle_lut #(.K(K-1)) u_tab (
      .mask_i(mask_i[h*HW +: HW]),
      .sel_i (half_idx),
      .out_o (f_half[h])
    );
  end

  assign f_sel  = lut_mode ? f_full : f_half[0];
  assign comb_o = casc_or_i ? (f_sel | casc_i) : (f_sel & casc_i);
  assign cout_o = lut_mode ? 1'b0 : f_half[1];
endmodule

// File: rtl/mle_reg.sv
module mle_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic aclr_i,
  input  logic apre_i,
  input  logic ena_i,
  input  logic cnt_i,
  input  logic sclr_i,
  input  logic sload_i,
  input  logic ld_val_i,
  input  logic d_i,
  output logic q_o
);
  logic d_nxt;

  always_comb begin
    d_nxt = d_i;
    if (cnt_i) begin
      if (sclr_i)       d_nxt = 1'b0;
      else if (sload_i) d_nxt = ld_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni or posedge aclr_i) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (aclr_i) q_o <= apre_i;
    else if (ena_i)  q_o <= d_nxt;
  end

  AST_HOLD_NO_ENA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ena_i && !aclr_i) |=> ($stable(q_o) || aclr_i)); // R9
  AST_SCLR_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ena_i && cnt_i && sclr_i && !aclr_i) |=> (!q_o || aclr_i)); // R7
  AST_SLOAD_VAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ena_i && cnt_i && !sclr_i && sload_i && !aclr_i) |=> ((q_o == $past(ld_val_i)) || aclr_i)); // R7
  AST_ASYNC_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aclr_i |-> (q_o == apre_i)); // R11
endmodule

// File: rtl/multimode_le.sv
module multimode_le
  import mle_pkg::*;
#(
  parameter int LUT_K = 4,
  parameter int N_SHARED = 2,
  localparam int MASK_W = 1 << LUT_K,
  localparam int SEL_W = (N_SHARED > 1) ? $clog2(N_SHARED) : 1
) (
  input  logic              clk0_i,
  input  logic              clk1_i,
  input  logic              rst_ni,
  input  logic              blk_clr0_i,
  input  logic              blk_clr1_i,
  input  logic              ena0_i,
  input  logic              ena1_i,
  input  logic [MASK_W-1:0] cfg_mask_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic              cfg_casc_or_i,
  input  logic [SEL_W-1:0]  cfg_clk_sel_i,
  input  logic [SEL_W-1:0]  cfg_ena_sel_i,
  input  logic [N_SHARED-1:0] cfg_aclr_sel_i,
  input  logic              cfg_apre_i,
  input  logic [LUT_K-1:0]  data_i,
  input  logic              cin_i,
  input  logic              casc_i,
  input  logic              sload_i,
  input  logic              sclr_i,
  output logic              comb_o,
  output logic              reg_o,
  output logic              cout_o,
  output logic              casc_o
);
  le_mode_e mode;
  logic     clk_g;
  logic     ena_g;
  logic     aclr_g;
  logic     comb;

  assign mode = le_mode_e'(cfg_mode_i);

  mle_ctrl #(.NSH(N_SHARED)) u_ctrl (
    .clk_i    ({clk1_i, clk0_i}),
    .ena_i    ({ena1_i, ena0_i}),
    .clr_i    ({blk_clr1_i, blk_clr0_i}),
    .clk_sel_i(cfg_clk_sel_i),
    .ena_sel_i(cfg_ena_sel_i),
    .clr_en_i (cfg_aclr_sel_i),
    .clk_o    (clk_g),
    .ena_o    (ena_g),
    .aclr_o   (aclr_g)
  );

  mle_datapath #(.K(LUT_K)) u_dp (
    .mode_i   (mode),
    .mask_i   (cfg_mask_i),
    .casc_or_i(cfg_casc_or_i),
    .data_i   (data_i),
    .cin_i    (cin_i),
    .casc_i   (casc_i),
    .q_i      (reg_o),
    .comb_o   (comb),
    .cout_o   (cout_o)
  );

  mle_reg u_reg (
    .clk_i   (clk_g),
    .rst_ni  (rst_ni),
    .aclr_i  (aclr_g),
    .apre_i  (cfg_apre_i),
    .ena_i   (ena_g),
    .cnt_i   (mode == MODE_CNT),
    .sclr_i  (sclr_i),
    .sload_i (sload_i),
    .ld_val_i(data_i[LUT_K-2]),
    .d_i     (comb),
    .q_o     (reg_o)
  );

  assign comb_o = comb;
  assign casc_o = comb;

  AST_LUT_NO_CARRY: assert property (@(posedge clk_g) disable iff (!rst_ni)
    is_lut_mode(mode) |-> !cout_o); // R3
  AST_CASC_AND_LOW: assert property (@(posedge clk_g) disable iff (!rst_ni)
    (!cfg_casc_or_i && !casc_i) |-> (!casc_o && !comb_o)); // R5
  AST_CASC_OR_HIGH: assert property (@(posedge clk_g) disable iff (!rst_ni)
    (cfg_casc_or_i && casc_i) |-> (casc_o && comb_o)); // R5
endmodule

// File: tb/sim_multimode_le.sv
`timescale 1ns/1ps
module sim_multimode_le;
  logic clk0 = 0, clk1 = 0, rst_n = 0;
  logic clr0 = 0, clr1 = 0, ena0 = 1, ena1 = 0;
  logic [15:0] mask = 16'h0;
  logic [1:0]  mode = 2'd0;
  logic        casc_or = 0, clk_sel = 0, ena_sel = 0, apre = 0;
  logic [1:0]  aclr_sel = 2'b00;
  logic [3:0]  data = 4'h0;
  logic        cin = 0, casc_in = 1, sload = 0, sclr = 0;
  logic        comb, rq, cout, casco;
  logic        mq = 0;
  int          total = 0, bad = 0;
  string       req = "R12";
  bit          done = 0;

  always #2.5 clk0 = ~clk0; // 200 MHz

  multimode_le u0 (
    .clk0_i(clk0), .clk1_i(clk1), .rst_ni(rst_n),
    .blk_clr0_i(clr0), .blk_clr1_i(clr1), .ena0_i(ena0), .ena1_i(ena1),
    .cfg_mask_i(mask), .cfg_mode_i(mode), .cfg_casc_or_i(casc_or),
    .cfg_clk_sel_i(clk_sel), .cfg_ena_sel_i(ena_sel),
    .cfg_aclr_sel_i(aclr_sel), .cfg_apre_i(apre),
    .data_i(data), .cin_i(cin), .casc_i(casc_in), .sload_i(sload), .sclr_i(sclr),
    .comb_o(comb), .reg_o(rq), .cout_o(cout), .casc_o(casco)
  );

  // reference model
  function automatic bit m_lut();
    return (mode == 2'd0) || (mode == 2'd3);
  endfunction
  function automatic int m_idx();
    if (m_lut()) return int'(data);
    return int'(cin) * 4 + int'(data[1]) * 2 + int'((mode == 2'd2) ? mq : data[0]);
  endfunction
  function automatic bit m_comb();
    bit f = mask[m_idx()];
    return casc_or ? (f | casc_in) : (f & casc_in);
  endfunction
  function automatic bit m_cout();
    if (m_lut()) return 1'b0;
    return mask[8 + m_idx()];
  endfunction

  task automatic m_step();
    bit en = ena_sel ? ena1 : ena0;
    bit asy = (aclr_sel[0] && clr0) || (aclr_sel[1] && clr1);
    if (!rst_n) mq = 1'b0;
    else if (asy) mq = apre;
    else if (en) begin
      if (mode == 2'd2 && sclr) mq = 1'b0;
      else if (mode == 2'd2 && sload) mq = data[2];
      else mq = m_comb();
    end
  endtask

  always @(posedge clk0 or posedge clk1) begin
    if (clk_sel) begin
      if (clk1) m_step();
    end else if (clk0) m_step();
  end

  task automatic cmp(string what, bit act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s at %0t: actual=%0b expected=%0b", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk0) if (!done) begin
    cmp("reg_o", rq, mq);
    cmp("comb_o", comb, m_comb());
    cmp("casc_o", casco, m_comb());
    cmp("cout_o", cout, m_cout());
  end

  task automatic tick(int n);
    repeat (n) begin
      @(negedge clk0);
      #1;
    end
  endtask

  initial begin
    // R12: reset state
    req = "R12"; tick(3); rst_n = 1;
    // R2: 4-input lookup, parity mask
    req = "R2"; mode = 2'd0; mask = 16'h6996;
    for (int d = 0; d < 16; d++) begin data = 4'(d); tick(1); end
    mask = 16'h0123;
    for (int d = 0; d < 16; d++) begin data = 4'(15 - d); tick(1); end
    // R3: no carry in lookup mode
    req = "R3"; mask = 16'hFFFF;
    for (int d = 0; d < 4; d++) begin data = 4'(d * 5); tick(1); end
    // R1: code 3 same as lookup
    req = "R1"; mode = 2'd3; mask = 16'h8001;
    for (int d = 0; d < 16; d++) begin data = 4'(d); tick(1); end
    // R4: full adder masks (sum 0x96, carry 0xE8)
    req = "R4"; mode = 2'd1; mask = 16'hE896;
    for (int v = 0; v < 16; v++) begin
      cin = v[2]; data = {v[3], ~v[3], v[1], v[0]}; tick(1);
    end
    cin = 0;
    // R5: cascade AND / OR in several modes
    req = "R5"; mode = 2'd0; mask = 16'h6996; casc_in = 0;
    for (int d = 0; d < 4; d++) begin data = 4'(d); tick(1); end
    casc_or = 1;
    for (int d = 0; d < 4; d++) begin data = 4'(d); tick(1); end
    casc_in = 1; tick(2);
    mode = 2'd1; mask = 16'hE896; casc_in = 0;
    for (int d = 0; d < 4; d++) begin data = 4'(d); tick(1); end
    casc_or = 0; casc_in = 1; data = 4'h0;
    // R8: sync controls ignored outside counter mode
    req = "R8"; mode = 2'd0; mask = 16'h6996; sload = 1; sclr = 1;
    for (int d = 0; d < 6; d++) begin data = 4'(d * 3); tick(1); end
    mode = 2'd1; mask = 16'hE896;
    for (int d = 0; d < 4; d++) begin data = 4'(d); tick(1); end
    sload = 0; sclr = 0;
    // R6: counter toggle (sum q^cin 0x5A, carry q&cin 0xA0)
    req = "R6"; mode = 2'd2; mask = 16'hA05A; data = 4'h0; cin = 1; tick(6);
    cin = 0; tick(2); cin = 1; tick(1);
    // R7: priorities
    req = "R7"; sload = 1; data = 4'b0100; tick(2);
    data = 4'b0000; tick(2);
    data = 4'b0100; tick(1);
    sclr = 1; tick(2);
    sclr = 0; sload = 0; tick(3);
    // R9: enable select and hold
    req = "R9"; ena0 = 0; tick(2); sclr = 1; tick(2); sclr = 0; sload = 1; data = 4'b0100; tick(2);
    sload = 0; ena_sel = 1; ena0 = 1; ena1 = 0; tick(3);
    ena1 = 1; tick(3);
    ena_sel = 0; ena1 = 0;
    // R10: clock select
    req = "R10"; clk_sel = 1; tick(3);
    repeat (3) begin clk1 = 1; #0.5; clk1 = 0; tick(1); end
    tick(2); clk_sel = 0; tick(3);
    // R11: asynchronous clears
    req = "R11"; mode = 2'd0; mask = 16'hFFFF; tick(2);
    aclr_sel = 2'b01; apre = 0; clr0 = 1; tick(2); clr0 = 0; tick(2);
    clr1 = 1; tick(2); clr1 = 0; tick(1);
    aclr_sel = 2'b10; clr1 = 1; tick(2); clr1 = 0; tick(2);
    mask = 16'h0000; apre = 1; aclr_sel = 2'b01; clr0 = 1; tick(2); clr0 = 0; tick(2);
    mode = 2'd2; mask = 16'hA05A; sclr = 1; apre = 1; clr0 = 1; tick(2);
    clr0 = 0; sclr = 0; tick(2);
    // R12: chip reset overrides preset
    req = "R12"; mode = 2'd0; mask = 16'hFFFF; apre = 1; clr0 = 1; rst_n = 0; tick(2);
    clr0 = 0; tick(1); rst_n = 1; tick(3);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule